// File: doc/BRIEF.md
# Four-Input ADC Conversion Sequencer

This block is the digital controller for a four-input, 8-bit two-step converter. The analog front end is modelled as a synchronous interface. The controller selects the multiplexer input and drives one strobe for each conversion phase: auto-zero, sample, coarse and fine. The front end returns a 5-bit coarse code and a 3-bit fine code, and the controller joins them into one 8-bit result. It writes that result into one of four result registers and raises a sticky end-of-conversion interrupt.

Software-visible settings arrive as plain configuration inputs:

- an enable bit;
- a 3-bit divider code, which sets the conversion tick rate from the system clock;
- a trigger-source field;
- a 2-bit sequencing mode;
- a first-channel field;
- an interrupt enable and an interrupt point select.

A conversion can be started by a control-register write strobe or by a time-out pulse from one of two timers. A start that arrives while a run is in progress abandons that run and begins a new one at once.

Each phase lasts one conversion tick. A conversion therefore takes four ticks.

State machine:

| State | Meaning |
|---|---|
| ST_IDLE | No conversion in progress |
| ST_ZERO | Auto-zero phase |
| ST_SAMPLE | Sample phase |
| ST_COARSE | Coarse phase |
| ST_FINE | Fine phase |

Transitions:

- **go_start**: any state to ST_ZERO, on an accepted trigger.
- **tick_zero**: ST_ZERO to ST_SAMPLE.
- **tick_sample**: ST_SAMPLE to ST_COARSE.
- **tick_coarse**: ST_COARSE to ST_FINE. The coarse code is captured on this tick.
- **tick_next**: ST_FINE to ST_ZERO, when the group has more conversions.
- **tick_done**: ST_FINE to ST_IDLE, when the group is complete.
- **go_off**: any state to ST_IDLE, when the enable bit is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the following are all zero: the four result registers, `irq`, `busy` and every phase strobe.
- R2: `cfg_div` codes 0..7 select a tick period of 2, 4, 8, 10, 16, 20, 32 or 40 system clocks. Each phase lasts one period. A result becomes visible exactly 4 periods after the clock edge that accepted the start.
- R3: The phases run in the order zero, sample, coarse, fine, and at most one phase strobe is high at a time. The coarse code is captured at the end of the coarse phase. The fine code is captured at the end of the fine phase. The stored value is {coarse, fine}, with coarse in bits 7:3. Result registers change only at the end of a fine phase.
- R4: The trigger source is set by `cfg_src`:
  - 0: `ctl_wr`
  - 1: `tmr0_tmo`
  - 2: `tmr2_tmo`
  - 3: no trigger
  Pulses on the pins that are not selected are ignored.
- R5: Mode 0 (`cfg_mode`=0) converts `cfg_first_ch` once. The result goes into the register whose index equals that channel.
- R6: Mode 1 converts `cfg_first_ch` four times. The results go into registers 0, 1, 2 and 3, in that order.
- R7: Mode 2 converts each channel once. It starts at `cfg_first_ch`, ascends and wraps from 3 to 0. Each result goes into the register indexed by its own channel.
- R8: Mode 3 repeats the mode-2 sweep without end, until a new start arrives or the block is disabled.
- R9: A trigger accepted during a run abandons that run without writing its partial result. The new run restarts in the zero phase on the newly selected channel.
- R10: When `cfg_irq_en` is 1, the pending flag is set at the end of a group's first conversion if `cfg_irq_sel`=0, or at the end of its fourth conversion if `cfg_irq_sel`=1. When `cfg_irq_en` is 0, the flag is never set.
- R11: `irq` stays high until `irq_clr` is pulsed, and it falls only in the cycle after such a pulse.
- R12: While `cfg_en` is 0, no trigger is accepted and the sequencer returns to idle. Result registers that are already written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Converter enable |
| cfg_div | input | 3 | Tick divider code |
| cfg_src | input | 2 | Trigger source select |
| cfg_mode | input | 2 | Sequencing mode |
| cfg_first_ch | input | 2 | Channel converted first |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_sel | input | 1 | Interrupt after first (0) or fourth (1) conversion |
| ctl_wr | input | 1 | Control-register write strobe (trigger) |
| tmr0_tmo | input | 1 | Timer 0 time-out pulse |
| tmr2_tmo | input | 1 | Timer 2 time-out pulse |
| irq_clr | input | 1 | Write-one-to-clear for the pending flag |
| coarse_code | input | 5 | Coarse code from the front end |
| fine_code | input | 3 | Fine code from the front end |
| ana_ch | output | 2 | Multiplexer channel select |
| ana_zero | output | 1 | Auto-zero phase strobe |
| ana_sample | output | 1 | Sample phase strobe |
| ana_coarse | output | 1 | Coarse phase strobe |
| ana_fine | output | 1 | Fine phase strobe |
| busy | output | 1 | Sequencer not idle |
| res_data | output | 32 | Four results; register k in bits 8k+7:8k |
| irq | output | 1 | Pending end-of-conversion interrupt |

## Verification
The bench builds the block with its default parameters: four channels, a 5-bit coarse code, a 3-bit fine code and a 6-bit tick counter. That counter is wide enough for the divide-by-40 code, so the bench can measure latency at both the shortest and the longest tick periods. Four channels with a two-bit index let the sweep modes reach the wrap from channel 3 to channel 0. The fourth-conversion interrupt point can also be reached. The bench's front-end model returns codes that depend on the selected channel and on a running conversion count. Because of that, every result it expects is distinct, and a wrong slot, a wrong channel or a stray write shows up in the monitor.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_SAMPLE,
        ST_COARSE,
        ST_FINE
    } conv_state_e;

    typedef enum logic [1:0] {
        MD_ONCE   = 2'd0,
        MD_REPEAT = 2'd1,
        MD_SWEEP  = 2'd2,
        MD_LOOP   = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        SRC_WRITE = 2'd0,
        SRC_TMR0  = 2'd1,
        SRC_TMR2  = 2'd2,
        SRC_NONE  = 2'd3
    } trig_src_e;

    // Divider code to tick period in system clocks.
    function automatic int unsigned div_ratio(input logic [2:0] code);
        int unsigned r;
        unique case (code)
            3'd0: r = 2;
            3'd1: r = 4;
            3'd2: r = 8;
            3'd3: r = 10;
            3'd4: r = 16;
            3'd5: r = 20;
            3'd6: r = 32;
            default: r = 40;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(div_ratio(div_code) - 1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic       en,
    input  logic [1:0] src,
    input  logic       ctl_wr,
    input  logic       tmr0_tmo,
    input  logic       tmr2_tmo,
    output logic       start
);
    logic picked;

    always_comb begin
        unique case (trig_src_e'(src))
            SRC_WRITE: picked = ctl_wr;
            SRC_TMR0:  picked = tmr0_tmo;
            SRC_TMR2:  picked = tmr2_tmo;
            default:   picked = 1'b0;
        endcase
    end

    assign start = en && picked;
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int COARSE_W = 5,
    parameter int FINE_W   = 3,
    localparam int CH_W    = $clog2(NCH),
    localparam int RES_W   = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                start,
    input  logic                tick,
    input  logic [1:0]          mode_in,
    input  logic [CH_W-1:0]     first_ch,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    output logic [CH_W-1:0]     ana_ch,
    output logic                ana_zero,
    output logic                ana_sample,
    output logic                ana_coarse,
    output logic                ana_fine,
    output logic                busy,
    output logic                wr_en,
    output logic [CH_W-1:0]     wr_slot,
    output logic [CH_W-1:0]     wr_idx,
    output logic [RES_W-1:0]    wr_data
);
    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NCH - 1);

    conv_state_e         state_q, state_d;
    seq_mode_e           mode_q;
    logic [CH_W-1:0]     idx_q;
    logic [CH_W-1:0]     ch_q;
    logic [COARSE_W-1:0] coarse_q;
    logic                more;
    logic                stepping;

    // Does the group continue after the current conversion?
    always_comb begin
        unique case (mode_q)
            MD_ONCE:   more = 1'b0;
            MD_REPEAT: more = (idx_q != LAST_IDX);
            MD_SWEEP:  more = (idx_q != LAST_IDX);
            default:   more = 1'b1;
        endcase
    end

    assign stepping = (mode_q == MD_SWEEP) || (mode_q == MD_LOOP);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;                        // go_off
        end else if (start) begin
            state_d = ST_ZERO;                        // go_start
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ZERO:   state_d = ST_SAMPLE;       // tick_zero
                ST_SAMPLE: state_d = ST_COARSE;       // tick_sample
                ST_COARSE: state_d = ST_FINE;         // tick_coarse
                ST_FINE:   state_d = more ? ST_ZERO   // tick_next
                                          : ST_IDLE;  // tick_done
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequence datapath: mode, conversion index, channel, coarse capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_ONCE;
            idx_q    <= '0;
            ch_q     <= '0;
            coarse_q <= '0;
        end else if (en && start) begin
            mode_q <= seq_mode_e'(mode_in);
            idx_q  <= '0;
            ch_q   <= first_ch;
        end else if (en && tick) begin
            if (state_q == ST_COARSE) begin
                coarse_q <= coarse_code;
            end
            if (state_q == ST_FINE) begin
                idx_q <= idx_q + 1'b1;
                if (stepping) begin
                    ch_q <= ch_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        ana_zero   = 1'b0;
        ana_sample = 1'b0;
        ana_coarse = 1'b0;
        ana_fine   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ZERO:   ana_zero   = 1'b1;
            ST_SAMPLE: ana_sample = 1'b1;
            ST_COARSE: ana_coarse = 1'b1;
            ST_FINE:   ana_fine   = 1'b1;
            default:   ;
        endcase
        ana_ch  = ch_q;
        busy    = (state_q != ST_IDLE);
        wr_en   = en && !start && tick && (state_q == ST_FINE);
        wr_slot = (mode_q == MD_REPEAT) ? idx_q : ch_q;
        wr_idx  = idx_q;
        wr_data = {coarse_q, fine_code};
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int COARSE_W = 5,
    parameter int FINE_W   = 3,
    parameter int CNT_W    = 6,
    localparam int CH_W    = $clog2(NCH),
    localparam int RES_W   = COARSE_W + FINE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [2:0]           cfg_div,
    input  logic [1:0]           cfg_src,
    input  logic [1:0]           cfg_mode,
    input  logic [CH_W-1:0]      cfg_first_ch,
    input  logic                 cfg_irq_en,
    input  logic                 cfg_irq_sel,
    input  logic                 ctl_wr,
    input  logic                 tmr0_tmo,
    input  logic                 tmr2_tmo,
    input  logic                 irq_clr,
    input  logic [COARSE_W-1:0]  coarse_code,
    input  logic [FINE_W-1:0]    fine_code,
    output logic [CH_W-1:0]      ana_ch,
    output logic                 ana_zero,
    output logic                 ana_sample,
    output logic                 ana_coarse,
    output logic                 ana_fine,
    output logic                 busy,
    output logic [NCH*RES_W-1:0] res_data,
    output logic                 irq
);
    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NCH - 1);

    logic             start_w;
    logic             tick_w;
    logic             wr_en;
    logic [CH_W-1:0]  wr_slot;
    logic [CH_W-1:0]  wr_idx;
    logic [RES_W-1:0] wr_data;
    logic             irq_evt;
    logic             irq_q;

    adc_trig_sel u_trig (
        .en       (cfg_en),
        .src      (cfg_src),
        .ctl_wr   (ctl_wr),
        .tmr0_tmo (tmr0_tmo),
        .tmr2_tmo (tmr2_tmo),
        .start    (start_w)
    );

    adc_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (start_w),
        .div_code (cfg_div),
        .tick     (tick_w)
    );

    adc_conv_fsm #(
        .NCH      (NCH),
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_en),
        .start       (start_w),
        .tick        (tick_w),
        .mode_in     (cfg_mode),
        .first_ch    (cfg_first_ch),
        .coarse_code (coarse_code),
        .fine_code   (fine_code),
        .ana_ch      (ana_ch),
        .ana_zero    (ana_zero),
        .ana_sample  (ana_sample),
        .ana_coarse  (ana_coarse),
        .ana_fine    (ana_fine),
        .busy        (busy),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data)
    );

    // Result registers
    for (genvar s = 0; s < NCH; s++) begin : g_res
        logic [RES_W-1:0] res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else if (wr_en && (wr_slot == CH_W'(s))) begin
                res_q <= wr_data;
            end
        end
        assign res_data[s*RES_W +: RES_W] = res_q;
    end

    // Sticky interrupt; a set in the same cycle wins over a clear
    assign irq_evt = wr_en && cfg_irq_en &&
                     (cfg_irq_sel ? (wr_idx == LAST_IDX) : (wr_idx == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (irq_evt) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int NCH   = 4,
    parameter int RES_W = 8,
    parameter int CH_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_en,
    input logic [CH_W-1:0]      cfg_first_ch,
    input logic                 irq_clr,
    input logic                 start_w,
    input logic                 wr_en,
    input logic [CH_W-1:0]      ana_ch,
    input logic                 ana_zero,
    input logic                 ana_sample,
    input logic                 ana_coarse,
    input logic                 ana_fine,
    input logic                 busy,
    input logic [NCH*RES_W-1:0] res_data,
    input logic                 irq
);
    assert_phase_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ana_zero, ana_sample, ana_coarse, ana_fine}));

    assert_zero_before_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_sample) |-> $past(ana_zero));

    assert_write_after_fine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_data) |-> $past(ana_fine));

    assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (ana_zero && ana_ch == $past(cfg_first_ch)));

    assert_off_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy);

    assert_off_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !wr_en);

    assert_irq_falls_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .NCH   (NCH),
    .RES_W (RES_W),
    .CH_W  (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .cfg_first_ch (cfg_first_ch),
    .irq_clr      (irq_clr),
    .start_w      (start_w),
    .wr_en        (wr_en),
    .ana_ch       (ana_ch),
    .ana_zero     (ana_zero),
    .ana_sample   (ana_sample),
    .ana_coarse   (ana_coarse),
    .ana_fine     (ana_fine),
    .busy         (busy),
    .res_data     (res_data),
    .irq          (irq)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_div = 3'd0;
    logic [1:0]  cfg_src = 2'd0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_first_ch = 2'd0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_irq_sel = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        tmr0_tmo = 1'b0;
    logic        tmr2_tmo = 1'b0;
    logic        irq_clr = 1'b0;
    logic [4:0]  coarse_code;
    logic [2:0]  fine_code;
    logic [1:0]  ana_ch;
    logic        ana_zero, ana_sample, ana_coarse, ana_fine, busy, irq;
    logic [31:0] res_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int start_cyc = 0;
    int last_wr_cyc = 0;
    logic [2:0]  seq = 3'd0;
    logic        smp_q = 1'b0;
    logic [31:0] prev_res = '0;
    logic [9:0]  exp_q[$];

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_div(cfg_div),
        .cfg_src(cfg_src), .cfg_mode(cfg_mode), .cfg_first_ch(cfg_first_ch),
        .cfg_irq_en(cfg_irq_en), .cfg_irq_sel(cfg_irq_sel), .ctl_wr(ctl_wr),
        .tmr0_tmo(tmr0_tmo), .tmr2_tmo(tmr2_tmo), .irq_clr(irq_clr),
        .coarse_code(coarse_code), .fine_code(fine_code), .ana_ch(ana_ch),
        .ana_zero(ana_zero), .ana_sample(ana_sample), .ana_coarse(ana_coarse),
        .ana_fine(ana_fine), .busy(busy), .res_data(res_data), .irq(irq)
    );

    // Front-end model: codes depend on channel and conversion count
    assign coarse_code = {ana_ch, seq};
    assign fine_code   = seq ^ 3'b101;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        smp_q <= ana_sample;
        if (ana_sample && !smp_q) seq <= seq + 3'd1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: every result change must match the head of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < 4; s++) begin
                if (res_data[s*8 +: 8] != prev_res[s*8 +: 8]) begin
                    last_wr_cyc = cyc;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9/R12", "unexpected write slot", s, 0);
                    end else begin
                        logic [9:0] e;
                        e = exp_q.pop_front();
                        chk(s == int'(e[9:8]) && res_data[s*8 +: 8] == e[7:0],
                            "R3/R5-R8", "slot,value",
                            (s << 8) | int'(res_data[s*8 +: 8]), int'(e));
                    end
                end
            end
            prev_res = res_data;
        end
    end

    // Driver: push the expected results for a run
    task automatic push_exp(input int mode, input int first, input logic [2:0] base);
        int n;
        n = (mode == 0) ? 1 : (mode == 3) ? 8 : 4;
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            logic [1:0] ch;
            logic [1:0] slot;
            logic [2:0] s;
            ch   = (mode >= 2) ? 2'(first + i) : 2'(first);
            slot = (mode == 1) ? 2'(i) : ch;
            s    = base + 3'(i + 1);
            exp_q.push_back({slot, ch, s, s ^ 3'b101});
        end
    endtask

    // which: 0 ctl_wr, 1 tmr0, 2 tmr2
    task automatic fire(input int which, input bit expect_run);
        @(negedge clk);
        case (which)
            0: ctl_wr = 1'b1;
            1: tmr0_tmo = 1'b1;
            default: tmr2_tmo = 1'b1;
        endcase
        @(posedge clk);
        #1;
        if (expect_run) begin
            start_cyc = cyc;
            push_exp(int'(cfg_mode), int'(cfg_first_ch), seq);
        end
        @(negedge clk);
        ctl_wr = 1'b0; tmr0_tmo = 1'b0; tmr2_tmo = 1'b0;
    endtask

    task automatic wait_empty(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, "pending results", exp_q.size(), 0);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(res_data == 0, "R1", "results", res_data, 0);
        chk(!irq && !busy, "R1", "irq/busy", {irq, busy}, 0);
        chk({ana_zero, ana_sample, ana_coarse, ana_fine} == 0, "R1", "phases",
            {ana_zero, ana_sample, ana_coarse, ana_fine}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_en = 1'b1;

        // R5 single, R2 latency with divide-by-10, R10 first-conversion irq
        cfg_div = 3'd3; cfg_mode = 2'd0; cfg_first_ch = 2'd2;
        cfg_irq_en = 1'b1; cfg_irq_sel = 1'b0; cfg_src = 2'd0;
        fire(0, 1'b1);
        @(negedge clk);
        chk(ana_zero && ana_ch == 2'd2, "R3", "zero phase on channel", ana_ch, 2);
        wait_empty("R5");
        chk(last_wr_cyc - start_cyc == 40, "R2", "latency div10", last_wr_cyc - start_cyc, 40);
        chk(irq == 1'b1, "R10", "irq after first", irq, 1);
        // R11 sticky, then cleared
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R11", "irq sticky", irq, 1);
        clear_irq();
        chk(irq == 1'b0, "R11", "irq cleared", irq, 0);

        // R6 repeat into slots 0..3
        cfg_div = 3'd0; cfg_mode = 2'd1; cfg_first_ch = 2'd1; cfg_irq_en = 1'b0;
        fire(0, 1'b1);
        wait_empty("R6");
        chk(!busy, "R6", "idle after group", busy, 0);

        // R7 sweep with wrap, R10 fourth-conversion irq
        cfg_mode = 2'd2; cfg_first_ch = 2'd3; cfg_irq_en = 1'b1; cfg_irq_sel = 1'b1;
        fire(0, 1'b1);
        wait (exp_q.size() == 1);
        chk(irq == 1'b0, "R10", "no irq before fourth", irq, 0);
        wait_empty("R7");
        chk(irq == 1'b1, "R10", "irq after fourth", irq, 1);
        clear_irq();

        // R4 trigger source selection
        cfg_mode = 2'd0; cfg_first_ch = 2'd0; cfg_irq_en = 1'b0; cfg_src = 2'd1;
        fire(0, 1'b0);
        chk(!busy, "R4", "ctl_wr ignored on src1", busy, 0);
        fire(2, 1'b0);
        chk(!busy, "R4", "tmr2 ignored on src1", busy, 0);
        fire(1, 1'b1);
        wait_empty("R4");
        cfg_src = 2'd2; cfg_first_ch = 2'd3;
        fire(2, 1'b1);
        wait_empty("R4");
        cfg_src = 2'd3;
        fire(0, 1'b0); fire(1, 1'b0); fire(2, 1'b0);
        chk(!busy, "R4", "no trigger on src3", busy, 0);
        cfg_src = 2'd0;

        // R9 abort mid-run, R10 gated off
        cfg_mode = 2'd2; cfg_first_ch = 2'd0;
        fire(0, 1'b1);
        repeat (10) @(negedge clk);
        cfg_mode = 2'd0; cfg_first_ch = 2'd1;
        fire(0, 1'b1);
        wait_empty("R9");
        repeat (20) @(negedge clk);
        chk(!busy, "R9", "idle after restart run", busy, 0);
        chk(irq == 1'b0, "R10", "irq gated off", irq, 0);

        // R8 continuous, then R12 disable keeps results
        cfg_mode = 2'd3; cfg_first_ch = 2'd2;
        fire(0, 1'b1);
        wait_empty("R8");
        cfg_en = 1'b0;
        @(negedge clk);
        chk(!busy, "R12", "idle when disabled", busy, 0);
        begin
            logic [31:0] snap;
            snap = res_data;
            fire(0, 1'b0);
            repeat (40) @(negedge clk);
            chk(res_data == snap && !busy, "R12", "results kept", res_data, snap);
        end

        // R2 longest period (divide-by-40)
        cfg_en = 1'b1; cfg_div = 3'd7; cfg_mode = 2'd0; cfg_first_ch = 2'd0;
        fire(0, 1'b1);
        wait_empty("R2");
        chk(last_wr_cyc - start_cyc == 160, "R2", "latency div40", last_wr_cyc - start_cyc, 160);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule